// File: doc/BRIEF.md
# Bus Target Read Prefetch Controller

This block sits behind the read data path of a bus target. It turns a bus read transaction into a stream of word reads on an internal resource, and it holds the returned words in a small in-order buffer that the bus side drains one word per completed data phase. The main job of the block is to decide how far ahead of the bus it may read. That decision rests on three things: the read command, the run-time cache line size, and whether the addressed region is free of read side effects.

A transaction opens with a one-cycle start strobe. The strobe carries the command, the first word address, the line size and the prefetchable flag, and all four are latched. A plain read of a region with side effects never reads ahead. A line read stops at the end of the line that holds the next word the bus will take. A multiple read keeps going across line boundaries while the master holds its frame signal, limited only by the buffer. The transaction ends with the data phase the master completes while frame is low. Any words left in the buffer or still on their way back are then thrown away, and their number is reported on a discard count output.

Top module: `rd_prefetch_ctrl`

## Requirements
- R1: `txn_cmd` 4'b0110 selects a plain read, 4'b1110 a line read and 4'b1100 a multiple read. A start strobe with any other code leaves the block idle: no `mem_req`, no `bus_valid`, no discard report.
- R2: For a plain read with `pref_ok` low, a word is requested only when the buffer and the in-flight count are both empty, so at most one word is fetched and not yet delivered.
- R3: For a line read with `pref_ok` low, no request address lies beyond the last word of the cache line holding the next bus word. `line_sel` 0, 1, 2 and 3 give lines of 4, 8, 16 and 32 words, and the line is found by masking the low address bits.
- R4: Request addresses run consecutively from the start address. For a multiple read, requests continue across line boundaries while `frame_active` is high, until the buffer is full.
- R5: Buffered words plus outstanding requests never exceed 16. With the bus stalled, an unbounded read-ahead settles at exactly 16 requests.
- R6: With `pref_ok` high at the start strobe, any valid command reads ahead as a multiple read does.
- R7: While `frame_active` is low, the only request made is for the next bus word, and only when nothing is buffered or in flight.
- R8: `bus_data` presents words in increasing address order, one word per `data_ack` taken while `bus_valid` is high. A `data_ack` while `bus_valid` is low has no effect.
- R9: A `data_ack` taken with `frame_active` low ends the transaction. No further requests are made. Late responses are absorbed, and `discard_valid` pulses once with `discard_cnt` equal to the words fetched minus the words delivered. The block is then idle.
- R10: Synchronous active-low `rst_n` empties the buffer, clears the in-flight count and returns the block to idle, with `bus_valid`, `mem_req` and `discard_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start | input | 1 | One-cycle strobe opening a transaction |
| txn_cmd | input | 4 | Read command code, latched at start |
| txn_addr | input | AW | First word address, latched at start |
| line_sel | input | 2 | Cache line size code (4 << code words), latched at start |
| pref_ok | input | 1 | Region has no read side effects, latched at start |
| frame_active | input | 1 | Master frame level |
| data_ack | input | 1 | Bus data phase completed; takes one word |
| bus_valid | output | 1 | A buffered word is available |
| bus_data | output | DW | Word at the head of the buffer |
| mem_req | output | 1 | Internal read request this cycle |
| mem_addr | output | AW | Word address of the request |
| mem_rvalid | input | 1 | Read data returning, in request order |
| mem_rdata | input | DW | Returned read data |
| discard_valid | output | 1 | One-cycle pulse reporting a finished transaction |
| discard_cnt | output | clog2(DEPTH+1) | Words thrown away at the end of that transaction |

## Verification
The bench stalls the bus after a start and counts requests. This catches a line read that reads past the boundary, including from a mid-line start and with a 32-word line that the buffer clips. It also catches a plain read that runs ahead, a prefetchable plain read that fails to run ahead, and a buffer that overfills past 16 entries. Random transactions mix the commands, line sizes, stall patterns and `data_ack` pulses given while no word is ready. Every request is checked against the consecutive address stream and against the frame-low demand rule, and every delivered word against its address. A design that reorders, skips or double-pops shows up as a data mismatch. Early endings check that words still in flight are counted into the discard report rather than leaking into the next transaction, and a reset in the middle of a transaction must leave the block idle.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        FM_NONE   = 2'd0,
        FM_SINGLE = 2'd1,
        FM_LINE   = 2'd2,
        FM_MULTI  = 2'd3
    } fetch_mode_e;

    localparam logic [3:0] CMD_RD       = 4'b0110;
    localparam logic [3:0] CMD_RD_LINE  = 4'b1110;
    localparam logic [3:0] CMD_RD_MULTI = 4'b1100;

    function automatic fetch_mode_e decode_cmd(input logic [3:0] cmd, input logic pref);
        fetch_mode_e m;
        case (cmd)
            CMD_RD:       m = FM_SINGLE;
            CMD_RD_LINE:  m = FM_LINE;
            CMD_RD_MULTI: m = FM_MULTI;
            default:      m = FM_NONE;
        endcase
        if (pref && (m != FM_NONE)) begin
            m = FM_MULTI;
        end
        return m;
    endfunction

endpackage

// File: rtl/rdpf_buf.sv
module rdpf_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic                         valid,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL     = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH-1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } buf_regs_t;

    buf_regs_t r_q, r_d;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d = '0;
        end else begin
            if (push) r_d.wp = bump(r_q.wp);
            if (pop)  r_d.rp = bump(r_q.rp);
            r_d.cnt = r_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[r_q.wp] <= wdata;
    end

    assign rdata = mem_q[r_q.rp];
    assign valid = (r_q.cnt != '0);
    assign count = r_q.cnt;

    AST_BUF_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> ((r_q.cnt < FULL) || pop)); // R5
    AST_BUF_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (r_q.cnt != '0)); // R8

endmodule

// File: rtl/rdpf_window.sv
module rdpf_window
    import rdpf_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DEPTH    = 16,
    parameter int MIN_LINE = 4
) (
    input  fetch_mode_e                  mode,
    input  logic [AW-1:0]                fetch_addr,
    input  logic [AW-1:0]                bus_addr,
    input  logic [$clog2(DEPTH+1):0]     inflight,
    input  logic                         frame,
    input  logic [1:0]                   lsel,
    output logic [AW-1:0]                line_last,
    output logic                         may_issue
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int N_LINE_CODES = 4;
    localparam logic [CW:0] CAP = (CW+1)'(DEPTH);

    logic [AW-1:0] line_mask [N_LINE_CODES];

    for (genvar g = 0; g < N_LINE_CODES; g++) begin : g_mask
        assign line_mask[g] = AW'((MIN_LINE << g) - 1);
    end

    assign line_last = bus_addr | line_mask[lsel];

    logic room, demand, ahead;

    always_comb begin
        room   = (inflight < CAP);
        demand = (inflight == '0);
        case (mode)
            FM_SINGLE: ahead = 1'b0;
            FM_LINE:   ahead = (fetch_addr <= line_last);
            FM_MULTI:  ahead = 1'b1;
            default:   ahead = 1'b0;
        endcase
        may_issue = room && (mode != FM_NONE) && (demand || (frame && ahead));
    end

endmodule

// File: rtl/rd_prefetch_ctrl.sv
module rd_prefetch_ctrl
    import rdpf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         txn_start,
    input  logic [3:0]                   txn_cmd,
    input  logic [AW-1:0]                txn_addr,
    input  logic [1:0]                   line_sel,
    input  logic                         pref_ok,
    input  logic                         frame_active,
    input  logic                         data_ack,
    output logic                         bus_valid,
    output logic [DW-1:0]                bus_data,
    output logic                         mem_req,
    output logic [AW-1:0]                mem_addr,
    input  logic                         mem_rvalid,
    input  logic [DW-1:0]                mem_rdata,
    output logic                         discard_valid,
    output logic [$clog2(DEPTH+1)-1:0]   discard_cnt
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW:0] CAP = (CW+1)'(DEPTH);

    typedef struct packed {
        ctl_state_e    st;
        fetch_mode_e   mode;
        logic [1:0]    lsel;
        logic [AW-1:0] fa;
        logic [AW-1:0] ba;
        logic [CW-1:0] outst;
        logic [CW-1:0] acc;
        logic          dvld;
        logic [CW-1:0] dcnt;
    } ctl_regs_t;

    ctl_regs_t r_q, r_d;

    logic          buf_valid, buf_pop, buf_push, buf_clr;
    logic [DW-1:0] buf_rdata;
    logic [CW-1:0] buf_cnt;
    logic [CW:0]   inflight;
    logic [AW-1:0] line_last;
    logic          may_issue, run, issue;
    fetch_mode_e   start_mode;

    assign inflight   = {1'b0, buf_cnt} + {1'b0, r_q.outst};
    assign run        = (r_q.st == ST_RUN);
    assign issue      = run && may_issue;
    assign buf_pop    = run && data_ack && buf_valid;
    assign buf_push   = run && mem_rvalid;
    assign buf_clr    = buf_pop && !frame_active;
    assign start_mode = decode_cmd(txn_cmd, pref_ok);

    rdpf_window #(.AW(AW), .DEPTH(DEPTH), .MIN_LINE(4)) u_window (
        .mode       (r_q.mode),
        .fetch_addr (r_q.fa),
        .bus_addr   (r_q.ba),
        .inflight   (inflight),
        .frame      (frame_active),
        .lsel       (r_q.lsel),
        .line_last  (line_last),
        .may_issue  (may_issue)
    );

    rdpf_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .push  (buf_push),
        .wdata (mem_rdata),
        .pop   (buf_pop),
        .rdata (buf_rdata),
        .valid (buf_valid),
        .count (buf_cnt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.dvld = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (txn_start && (start_mode != FM_NONE)) begin
                    r_d.st    = ST_RUN;
                    r_d.mode  = start_mode;
                    r_d.lsel  = line_sel;
                    r_d.fa    = txn_addr;
                    r_d.ba    = txn_addr;
                    r_d.outst = '0;
                    r_d.acc   = '0;
                end
            end
            ST_RUN: begin
                if (issue)   r_d.fa = r_q.fa + AW'(1);
                if (buf_pop) r_d.ba = r_q.ba + AW'(1);
                r_d.outst = r_q.outst + CW'(issue) - CW'(mem_rvalid);
                if (buf_clr) begin
                    r_d.st  = ST_FLUSH;
                    r_d.acc = buf_cnt - CW'(1) + CW'(mem_rvalid);
                end
            end
            ST_FLUSH: begin
                r_d.acc   = r_q.acc + CW'(mem_rvalid);
                r_d.outst = r_q.outst - CW'(mem_rvalid);
                if (r_d.outst == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.mode = FM_NONE;
                    r_d.dvld = 1'b1;
                    r_d.dcnt = r_d.acc;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_valid     = run && buf_valid;
    assign bus_data      = buf_rdata;
    assign mem_req       = issue;
    assign mem_addr      = r_q.fa;
    assign discard_valid = r_q.dvld;
    assign discard_cnt   = r_q.dcnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CAP); // R5
    AST_SINGLE_ONE_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (r_q.mode == FM_SINGLE)) |-> (inflight <= (CW+1)'(1))); // R2
    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (r_q.mode == FM_LINE) && (inflight != '0)) |-> ((r_q.fa - AW'(1)) <= line_last)); // R3
    AST_FRAME_DEMAND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !frame_active) |-> (mem_addr == r_q.ba)); // R7
    AST_REPORT_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        discard_valid |-> ((r_q.outst == '0) && !bus_valid)); // R9
    AST_DISCARD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        discard_valid |-> (discard_cnt < CW'(DEPTH))); // R9

endmodule

// File: tb/rd_prefetch_ctrl_tb.sv
module rd_prefetch_ctrl_tb;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH+1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 1'b0;
    logic [3:0] txn_cmd = '0;
    logic [AW-1:0] txn_addr = '0;
    logic [1:0] line_sel = '0;
    logic pref_ok = 1'b0;
    logic frame_active = 1'b0;
    logic data_ack = 1'b0;
    logic bus_valid;
    logic [DW-1:0] bus_data;
    logic mem_req;
    logic [AW-1:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic discard_valid;
    logic [CW-1:0] discard_cnt;

    rd_prefetch_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_cmd(txn_cmd),
        .txn_addr(txn_addr), .line_sel(line_sel), .pref_ok(pref_ok),
        .frame_active(frame_active), .data_ack(data_ack), .bus_valid(bus_valid),
        .bus_data(bus_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .discard_valid(discard_valid), .discard_cnt(discard_cnt)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int wd = 0;
    int issued, delivered, mode_b;
    logic [1:0] cur_lsel;
    logic [AW-1:0] exp_fa, exp_ba;
    bit chk_en, ended, disc_seen;
    int disc_val;
    logic [AW-1:0] mq [$];

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_bad++;
            $display("FAIL R9 watchdog expired: actual %0d cycles expected fewer", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    function automatic logic [AW-1:0] mask_of(input logic [1:0] ls);
        return AW'((4 << ls) - 1);
    endfunction

    function automatic int mode_of(input logic [3:0] c, input logic p);
        int m;
        case (c)
            4'b0110: m = 1;
            4'b1110: m = 2;
            4'b1100: m = 3;
            default: m = 0;
        endcase
        if (p && m != 0) m = 3;
        return m;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exv);
        end
    endtask

    // one clock cycle: entered at posedge+1, drives, samples at posedge+3
    task automatic cyc(input logic fr, input logic ack);
        frame_active = fr;
        data_ack = ack;
        if (mq.size() > 0 && ($urandom % 4) != 0) begin
            mem_rvalid = 1'b1;
            mem_rdata = pat(mq.pop_front());
        end else begin
            mem_rvalid = 1'b0;
        end
        #2;
        if (chk_en) begin
            if (mem_req) begin
                check(mode_b != 0, "R1 request for invalid command", 32'(mem_req), 32'd0);
                check(!ended, "R9 request after end", 32'(mem_addr), 32'd0);
                check(mem_addr == exp_fa, "R4 request address", 32'(mem_addr), 32'(exp_fa));
                check((issued - delivered) < DEPTH, "R5 capacity", 32'(issued - delivered), 32'(DEPTH - 1));
                if (mode_b == 1)
                    check(issued == delivered, "R2 plain read ahead", 32'(issued - delivered), 32'd0);
                if (mode_b == 2)
                    check(mem_addr <= (exp_ba | mask_of(cur_lsel)), "R3 line bound",
                          32'(mem_addr), 32'(exp_ba | mask_of(cur_lsel)));
                if (!fr)
                    check(issued == delivered, "R7 fetch ahead with frame low", 32'(issued - delivered), 32'd0);
                mq.push_back(mem_addr);
                issued++;
                exp_fa = exp_fa + 1'b1;
            end
            if (mode_b == 0 && bus_valid)
                check(1'b0, "R1 data for invalid command", 32'(bus_valid), 32'd0);
            if (ack && bus_valid) begin
                check(bus_data == pat(exp_ba), "R8 bus word order", bus_data, pat(exp_ba));
                exp_ba = exp_ba + 1'b1;
                delivered++;
                if (!fr) ended = 1'b1;
            end
            if (discard_valid) begin
                disc_seen = 1'b1;
                disc_val = int'(discard_cnt);
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run_txn(input logic [3:0] cmd, input logic [AW-1:0] addr, input logic [1:0] ls,
                           input logic pref, input int nwords, input int ackpct,
                           input int stall, input int exp_stall, input string stag);
        int guard;
        txn_cmd = cmd; txn_addr = addr; line_sel = ls; pref_ok = pref;
        mode_b = mode_of(cmd, pref);
        cur_lsel = ls;
        exp_fa = addr; exp_ba = addr;
        issued = 0; delivered = 0; ended = 1'b0; disc_seen = 1'b0;
        txn_start = 1'b1;
        cyc(1'b1, 1'b0);
        txn_start = 1'b0;
        if (mode_b == 0) begin
            repeat (20) cyc(1'b1, 1'($urandom % 2));
            check(issued == 0, "R1 invalid command requests", 32'(issued), 32'd0);
            check(!disc_seen, "R1 invalid command report", 32'(disc_seen), 32'd0);
            return;
        end
        repeat (stall) cyc(1'b1, 1'b0);
        if (exp_stall >= 0)
            check(issued == exp_stall, stag, 32'(issued), 32'(exp_stall));
        guard = 0;
        while (!ended && guard < 4000) begin
            cyc((delivered < nwords - 1) ? 1'b1 : 1'b0, (($urandom % 100) < ackpct) ? 1'b1 : 1'b0);
            guard++;
        end
        check(ended, "R9 transaction end reached", 32'(delivered), 32'(nwords));
        for (int k = 0; k < 80 && !disc_seen; k++) cyc(1'b0, 1'b0);
        check(disc_seen, "R9 discard report", 32'(disc_seen), 32'd1);
        check(disc_val == issued - delivered, "R9 discard count", 32'(disc_val), 32'(issued - delivered));
        check(mq.size() == 0, "R9 responses drained", 32'(mq.size()), 32'd0);
        cyc(1'b0, 1'b0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240613);
        chk_en = 1'b0;
        mode_b = 0;
        @(posedge clk);
        #1;
        repeat (3) cyc(1'b0, 1'b0);
        rst_n = 1'b1;
        chk_en = 1'b1;
        cyc(1'b1, 1'b0);
        check(!bus_valid && !mem_req && !discard_valid && discard_cnt == '0, "R10 reset state",
              {bus_valid, mem_req, discard_valid, 29'(discard_cnt)}, 32'd0);

        // directed read-ahead depth with the bus stalled
        run_txn(4'b1100, 16'h0100, 2'd0, 1'b0, 1, 100, 60, 16, "R4 multiple read fills buffer");
        run_txn(4'b1110, 16'h0105, 2'd1, 1'b0, 1, 100, 40, 3, "R3 line read mid-line start");
        run_txn(4'b1110, 16'h0200, 2'd3, 1'b0, 1, 100, 60, 16, "R5 line of 32 clipped by buffer");
        run_txn(4'b1110, 16'h0303, 2'd0, 1'b0, 1, 100, 40, 1, "R3 line read at last word");
        run_txn(4'b1110, 16'h0320, 2'd2, 1'b0, 1, 100, 40, 16, "R3 line of 16 from line start");
        run_txn(4'b0110, 16'h0400, 2'd0, 1'b0, 1, 100, 40, 1, "R2 plain read single word");
        run_txn(4'b0110, 16'h0500, 2'd0, 1'b1, 1, 100, 60, 16, "R6 prefetchable plain read");
        run_txn(4'b1110, 16'h0603, 2'd0, 1'b1, 1, 100, 60, 16, "R6 prefetchable line read");
        run_txn(4'b0111, 16'h0700, 2'd0, 1'b0, 1, 100, 0, -1, "R1");
        run_txn(4'b0010, 16'h0710, 2'd0, 1'b1, 1, 100, 0, -1, "R1");
        // bursts crossing lines and early endings
        run_txn(4'b1110, 16'h0802, 2'd0, 1'b0, 20, 100, 0, -1, "R3");
        run_txn(4'b1100, 16'h0900, 2'd1, 1'b0, 3, 60, 30, 16, "R4 multiple read early end");
        run_txn(4'b0110, 16'h0A00, 2'd0, 1'b0, 12, 50, 0, -1, "R2");
        run_txn(4'b1100, 16'h0B00, 2'd0, 1'b0, 40, 30, 0, -1, "R8");

        // reset in the middle of a transaction
        txn_cmd = 4'b1100; txn_addr = 16'h0C00; pref_ok = 1'b0; line_sel = 2'd0;
        mode_b = 3; exp_fa = 16'h0C00; exp_ba = 16'h0C00; issued = 0; delivered = 0; ended = 1'b0;
        txn_start = 1'b1;
        cyc(1'b1, 1'b0);
        txn_start = 1'b0;
        repeat (25) cyc(1'b1, 1'b0);
        chk_en = 1'b0;
        rst_n = 1'b0;
        repeat (2) cyc(1'b1, 1'b0);
        mq.delete();
        rst_n = 1'b1;
        chk_en = 1'b1;
        mode_b = 0;
        cyc(1'b1, 1'b1);
        check(!bus_valid, "R10 buffer emptied by reset", 32'(bus_valid), 32'd0);
        check(!mem_req, "R10 idle after reset", 32'(mem_req), 32'd0);
        repeat (10) cyc(1'b1, 1'b1);

        // random mix
        for (int t = 0; t < 40; t++) begin
            int sel;
            logic [3:0] c;
            sel = int'($urandom % 10);
            if (sel == 0)      c = 4'b0000;
            else if (sel < 4)  c = 4'b0110;
            else if (sel < 7)  c = 4'b1110;
            else               c = 4'b1100;
            run_txn(c, AW'(16'h0100 + ($urandom % 16'h7000)), 2'($urandom % 4),
                    1'(($urandom % 4) == 0), 1 + int'($urandom % 40), 30 + int'($urandom % 70),
                    (($urandom % 3) == 0) ? 12 : 0, -1, "R4");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule